// File: doc/BRIEF.md
# Semaphore Mailbox Slave with Locked Test-and-Set

This block is the slave side of a shared-memory synchronisation point between several bus masters and one local processor. The bus port accepts plain reads and writes plus an indivisible read-modify-write cycle. That cycle tests and sets a one-bit lock word. The master that finds the lock clear owns a guarded region. There it stores its board number and then posts a word into a mailbox, which raises an interrupt toward the local processor.

The local port reads the same registers. It services the mailbox by bumping a receive tally chosen by the stored board number. It then clears the acknowledge flag, which drops the interrupt. Only after that does the owning master release the lock. The tallies are held per board for up to 21 boards and saturate. A master can read them back through a select/data register pair. If two masters held the lock at once, the tallies show it: the tallies add up to more than the successful acquisitions.

Top module: `sem_mailbox`

## Requirements
- R1: After reset, the lock bit, the board number, the mailbox word, the status word, the tally select and every tally read zero, `irq` is low and `loc_ready` is high.
- R2: A bus cycle with `bus_rmw` high acts on the lock word whatever `bus_addr` holds. `bus_ack` rises two clock edges after acceptance, and `bus_rdata` then returns the previous lock value in bit 0 with zeros above. Bit 0 of the lock is 1 afterwards.
- R3: From the cycle in which a locked cycle is accepted until its write phase completes, `loc_ready` is low and any local access issued then has no effect.
- R4: A plain bus access is accepted in a cycle with `bus_req` high while the slave is idle. `bus_ack` is high for one cycle, one edge after acceptance, with read data in `bus_rdata`. The addresses are: 0 lock (bit 0), 1 board number, 2 mailbox, 3 status, 4 tally select, 5 tally data, 6 local increment strobe.
- R5: A bus write to address 2 stores the word and sets the acknowledge flag (status bit 0). `irq` equals that flag and stays high until a local write to address 3 clears it.
- R6: A local write to address 6 adds one to the tally indexed by the stored board number. It does nothing when the board number is 21 or more.
- R7: Each tally is 16 bits wide and holds at 0xFFFF once it gets there.
- R8: A bus write to address 1 while lock bit 0 is clear sets status bit 1. That bit stays set until reset.
- R9: Reading address 5 returns the tally chosen by the value last written to address 4. It returns zero when that value is 21 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access request, held until `bus_ack` |
| bus_rmw | input | 1 | Request is a locked test-and-set of the lock word |
| bus_we | input | 1 | Plain access is a write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Bus write data |
| bus_ack | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 16 | Read data, valid with `bus_ack` |
| loc_req | input | 1 | Local access request |
| loc_we | input | 1 | Local access is a write or strobe |
| loc_addr | input | 3 | Local register address |
| loc_wdata | input | 1 | Value written to lock bit 0 by the local side |
| loc_ready | output | 1 | Local write takes effect at the next edge when high |
| loc_rdata | output | 16 | Combinational local read data |
| irq | output | 1 | Mailbox interrupt to the local processor |

## Verification
The assertions assume that a bus master holds `bus_req` and its fields steady until it sees `bus_ack`, and drops the request in the cycle of the acknowledge. They also assume that the local side only counts a write as done in a cycle where `loc_ready` was high. The bench drives every request at the falling edge and waits for the acknowledge before it releases the request. It holds a local request across a locked cycle only to show that the request is stalled. Contending masters are modelled one after another from a deterministic pseudo-random sequence, so each test-and-set sees a known lock state.

// File: rtl/sem_mailbox_pkg.sv
// Shared constants and types for the semaphore mailbox slave.
// Assumes a three-bit register address space common to both ports.
package sem_mailbox_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_LOCK  = 3'd0;
    localparam logic [ADDR_W-1:0] A_OWNER = 3'd1;
    localparam logic [ADDR_W-1:0] A_MBOX  = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CSEL  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CDATA = 3'd5;
    localparam logic [ADDR_W-1:0] A_INC   = 3'd6;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SET  = 2'd1,
        SQ_ACK  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/sem_mailbox_seq.sv
// Bus-side cycle sequencer. Accepts one request at a time; a plain access
// completes in one edge, a locked test-and-set takes a capture edge and a
// set edge. Asserts the lock from acceptance through the set phase.
// Assumes the master holds bus_req until bus_ack and then drops it.
module sem_mailbox_seq #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_rmw,
    input  logic [DATA_W-1:0] rd_val,
    input  logic              lock_bit,
    output logic              accept,
    output logic              set_phase,
    output logic              lock,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata
);
    import sem_mailbox_pkg::*;

    seq_state_e state_q;

    // Decode strobes from the current state.
    always_comb begin
        accept    = (state_q == SQ_IDLE) && bus_req;
        set_phase = (state_q == SQ_SET);
        lock      = (accept && bus_rmw) || set_phase;
        bus_ack   = (state_q == SQ_ACK);
    end

    // Advance the sequencer and capture the read value at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            bus_rdata <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (bus_req) begin
                    bus_rdata <= bus_rmw ? {{(DATA_W-1){1'b0}}, lock_bit} : rd_val;
                    state_q   <= bus_rmw ? SQ_SET : SQ_ACK;
                end
                SQ_SET:  state_q <= SQ_ACK;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // R2: the set phase is always followed by the acknowledge.
    p_set_then_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_phase |=> bus_ack);

    // R4: the acknowledge lasts exactly one cycle.
    p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
endmodule

// File: rtl/sem_mailbox_cnt.sv
// Bank of saturating receive tallies, one per board. One tally can be
// bumped per cycle; one can be read combinationally.
// Assumes inc_idx and rd_idx were already range-checked by the caller.
module sem_mailbox_cnt #(
    parameter int N_BOARDS = 21,
    parameter int CNT_W    = 16,
    parameter int IDX_W    = $clog2(N_BOARDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [IDX_W-1:0] inc_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q [N_BOARDS];

    for (genvar i = 0; i < N_BOARDS; i++) begin : g_tally
        // Bump this tally when selected, holding at the maximum.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[i] <= '0;
            else if (inc_en && inc_idx == IDX_W'(i) && cnt_q[i] != CNT_MAX)
                cnt_q[i] <= cnt_q[i] + CNT_W'(1);
        end

        // R7: a full tally never wraps.
        p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[i] == CNT_MAX) |=> (cnt_q[i] == CNT_MAX));

        // R6: a tally only ever moves up by one.
        p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(cnt_q[i]) |-> (cnt_q[i] == $past(cnt_q[i]) + CNT_W'(1)));
    end

    // Select the tally named by rd_idx.
    always_comb begin
        rd_cnt = '0;
        for (int i = 0; i < N_BOARDS; i++)
            if (rd_idx == IDX_W'(i)) rd_cnt = cnt_q[i];
    end
endmodule

// File: rtl/sem_mailbox.sv
// Semaphore mailbox slave: lock word with locked test-and-set, guarded
// board-number register, mailbox with interrupt and acknowledge flag,
// protocol-error flag and per-board receive tallies.
// Assumes CNT_W <= DATA_W and N_BOARDS fits in DATA_W bits.
module sem_mailbox #(
    parameter int N_BOARDS = 21,
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bus_req,
    input  logic                               bus_rmw,
    input  logic                               bus_we,
    input  logic [sem_mailbox_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]                  bus_wdata,
    output logic                               bus_ack,
    output logic [DATA_W-1:0]                  bus_rdata,
    input  logic                               loc_req,
    input  logic                               loc_we,
    input  logic [sem_mailbox_pkg::ADDR_W-1:0] loc_addr,
    input  logic                               loc_wdata,
    output logic                               loc_ready,
    output logic [DATA_W-1:0]                  loc_rdata,
    output logic                               irq
);
    import sem_mailbox_pkg::*;

    localparam int               IDX_W = $clog2(N_BOARDS);
    localparam logic [DATA_W-1:0] N_LIM = DATA_W'(N_BOARDS);

    logic              lock_q, flag_q, err_q;
    logic [DATA_W-1:0] owner_q, mbox_q, csel_q;
    logic              accept, set_phase, lock;
    logic              bus_wr, loc_wr, inc_en;
    logic [DATA_W-1:0] bus_rd_val;
    logic [CNT_W-1:0]  rd_cnt;

    // Register read decode shared by both ports.
    function automatic logic [DATA_W-1:0] read_reg(input logic [ADDR_W-1:0] a);
        case (a)
            A_LOCK:  return {{(DATA_W-1){1'b0}}, lock_q};
            A_OWNER: return owner_q;
            A_MBOX:  return mbox_q;
            A_STAT:  return {{(DATA_W-2){1'b0}}, err_q, flag_q};
            A_CSEL:  return csel_q;
            A_CDATA: return (csel_q < N_LIM) ? DATA_W'(rd_cnt) : '0;
            default: return '0;
        endcase
    endfunction

    sem_mailbox_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_rmw   (bus_rmw),
        .rd_val    (bus_rd_val),
        .lock_bit  (lock_q),
        .accept    (accept),
        .set_phase (set_phase),
        .lock      (lock),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata)
    );

    sem_mailbox_cnt #(.N_BOARDS(N_BOARDS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (inc_en),
        .inc_idx (owner_q[IDX_W-1:0]),
        .rd_idx  (csel_q[IDX_W-1:0]),
        .rd_cnt  (rd_cnt)
    );

    // Port strobes, local stall and read data.
    always_comb begin
        bus_rd_val = read_reg(bus_addr);
        loc_rdata  = read_reg(loc_addr);
        loc_ready  = !lock;
        bus_wr     = accept && !bus_rmw && bus_we;
        loc_wr     = loc_req && loc_ready && loc_we;
        inc_en     = loc_wr && loc_addr == A_INC && owner_q < N_LIM;
        irq        = flag_q;
    end

    // Lock bit: set phase first, then bus writes, then local writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                              lock_q <= 1'b0;
        else if (set_phase)                      lock_q <= 1'b1;
        else if (bus_wr && bus_addr == A_LOCK)   lock_q <= bus_wdata[0];
        else if (loc_wr && loc_addr == A_LOCK)   lock_q <= loc_wdata;
    end

    // Bus-written data registers: board number, mailbox, tally select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
            mbox_q  <= '0;
            csel_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_OWNER) owner_q <= bus_wdata;
            if (bus_addr == A_MBOX)  mbox_q  <= bus_wdata;
            if (bus_addr == A_CSEL)  csel_q  <= bus_wdata;
        end
    end

    // Acknowledge flag: set by a mailbox write, cleared by the local side.
    always_ff @(posedge clk) begin
        if (!rst_n)                              flag_q <= 1'b0;
        else if (bus_wr && bus_addr == A_MBOX)   flag_q <= 1'b1;
        else if (loc_wr && loc_addr == A_STAT)   flag_q <= 1'b0;
    end

    // Sticky protocol error: board number written without holding the lock.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          err_q <= 1'b0;
        else if (bus_wr && bus_addr == A_OWNER && !lock_q)   err_q <= 1'b1;
    end

    // R3: nothing moves the lock between the capture and set phases.
    p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bus_rmw) |=> $stable(lock_q));

    // R2: the lock reads as taken right after the set phase.
    p_lock_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_phase |=> lock_q);

    // R8: the protocol-error flag never clears outside reset.
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R5: the interrupt holds until a local status write.
    p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(loc_req && loc_we && loc_addr == A_STAT)) |=> irq);
endmodule

// File: tb/sem_mailbox_test.sv
// Directed bench for the semaphore mailbox slave.
module sem_mailbox_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 0, bus_rmw = 0, bus_we = 0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_ack;
    logic [15:0] bus_rdata;
    logic        loc_req = 0, loc_we = 0, loc_wdata = 0;
    logic [2:0]  loc_addr = '0;
    logic        loc_ready;
    logic [15:0] loc_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int exp_cnt [1:6];
    int acquired = 0;

    localparam logic [2:0] LOCK = 0, OWNER = 1, MBOX = 2, STAT = 3,
                           CSEL = 4, CDATA = 5, INC = 6;

    sem_mailbox uut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_rmw(bus_rmw), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_ready(loc_ready), .loc_rdata(loc_rdata),
        .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic rmw, input logic we, input logic [2:0] a,
                          input logic [15:0] d, output logic [15:0] rd, output int lat);
        @(negedge clk);
        bus_req = 1; bus_rmw = rmw; bus_we = we; bus_addr = a; bus_wdata = d;
        lat = 0;
        do begin
            @(posedge clk); #1; lat++;
        end while (!bus_ack && lat < 10);
        rd = bus_rdata;
        @(negedge clk);
        bus_req = 0; bus_rmw = 0; bus_we = 0;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        logic [15:0] rd; int lat;
        bus_op(0, 1, a, d, rd, lat);
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] v);
        int lat;
        bus_op(0, 0, a, 16'h0, v, lat);
    endtask

    task automatic tas(output logic [15:0] old, output int lat);
        bus_op(1, 0, CSEL, 16'h0, old, lat);
    endtask

    task automatic loc_wr(input logic [2:0] a, input logic d);
        @(negedge clk);
        loc_req = 1; loc_we = 1; loc_addr = a; loc_wdata = d;
        @(posedge clk);
        @(negedge clk);
        loc_req = 0; loc_we = 0;
    endtask

    task automatic loc_rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        loc_addr = a;
        #1 v = loc_rdata;
    endtask

    task automatic read_tally(input int idx, output logic [15:0] v);
        bus_wr(CSEL, 16'(idx));
        bus_rd(CDATA, v);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        chk("R1 irq", irq, 0);
        chk("R1 loc_ready", loc_ready, 1);
        chk("R1 bus_ack", bus_ack, 0);
        for (int a = 0; a < 6; a++) begin
            loc_rd(3'(a), v);
            chk($sformatf("R1 reg %0d", a), v, 0);
        end
    endtask

    task automatic t_plain;
        logic [15:0] rd; int lat;
        bus_op(0, 1, CSEL, 16'h0007, rd, lat);
        chk("R4 write latency", lat, 1);
        bus_op(0, 0, CSEL, 16'h0, rd, lat);
        chk("R4 read latency", lat, 1);
        chk("R4 readback select", rd, 16'h0007);
        bus_rd(LOCK, rd);
        chk("R4 lock reads clear", rd, 0);
    endtask

    task automatic t_owner_err;
        logic [15:0] v;
        bus_wr(OWNER, 16'd5);
        bus_rd(STAT, v);
        chk("R8 error set when lock clear", v & 16'h2, 16'h2);
        bus_rd(OWNER, v);
        chk("R4 board number stored", v, 16'd5);
    endtask

    task automatic t_rmw;
        logic [15:0] old, v; int lat;
        tas(old, lat);
        chk("R2 tas latency", lat, 2);
        chk("R2 tas old clear", old, 0);
        bus_rd(LOCK, v);
        chk("R2 lock now set", v, 1);
        tas(old, lat);
        chk("R2 tas old set", old, 1);
        bus_wr(LOCK, 16'h0);
        bus_rd(STAT, v);
        chk("R8 error still sticky", v & 16'h2, 16'h2);
    endtask

    task automatic t_mailbox;
        logic [15:0] v;
        bus_wr(MBOX, 16'hABCD);
        chk("R5 irq raised", irq, 1);
        loc_rd(MBOX, v);
        chk("R5 mailbox word", v, 16'hABCD);
        loc_rd(STAT, v);
        chk("R5 flag set", v & 16'h1, 1);
        repeat (3) @(posedge clk);
        #1 chk("R5 irq held", irq, 1);
        loc_wr(STAT, 0);
        #1 chk("R5 irq cleared", irq, 0);
    endtask

    task automatic t_stall;
        logic [15:0] v;
        int lat;
        // Board number is 5, lock clear: start a tas with a local INC pending.
        @(negedge clk);
        bus_req = 1; bus_rmw = 1; bus_addr = LOCK;
        loc_req = 1; loc_we = 1; loc_addr = INC;
        #1 chk("R3 stalled at acceptance", loc_ready, 0);
        @(posedge clk); #1;
        chk("R3 stalled in set phase", loc_ready, 0);
        @(posedge clk); #1;
        chk("R2 ack after set", bus_ack, 1);
        chk("R2 old value", bus_rdata, 0);
        @(negedge clk);
        bus_req = 0; bus_rmw = 0; loc_req = 0; loc_we = 0;
        read_tally(5, v);
        chk("R3 stalled increment had no effect", v, 0);
        loc_wr(INC, 0);
        read_tally(5, v);
        chk("R6 increment by board number", v, 1);
        bus_wr(OWNER, 16'd25);
        loc_wr(INC, 0);
        read_tally(5, v);
        chk("R6 out-of-range board leaves tally", v, 1);
        read_tally(25, v);
        chk("R9 out-of-range select reads zero", v, 0);
        bus_wr(LOCK, 16'h0);
    endtask

    task automatic t_compete;
        logic [15:0] old, v;
        int lat, w, c, sum;
        int unsigned s = 7;
        for (int m = 1; m <= 6; m++) exp_cnt[m] = 0;
        exp_cnt[5] = 1;
        for (int r = 0; r < 8; r++) begin
            s = s * 1103515245 + 12345;
            w = int'((s >> 16) % 6) + 1;
            c = (w % 6) + 1;
            tas(old, lat);
            chk($sformatf("R2 master %0d acquires", w), old, 0);
            if (old == 0) begin
                acquired++;
                bus_wr(OWNER, 16'(w));
                tas(old, lat);
                chk($sformatf("R2 master %0d refused", c), old, 1);
                bus_wr(MBOX, 16'(w));
                #1 chk("R5 irq on post", irq, 1);
                loc_rd(OWNER, v);
                chk("R6 owner visible locally", v, 16'(w));
                loc_wr(INC, 0);
                exp_cnt[w]++;
                loc_wr(STAT, 0);
                #1 chk("R5 irq after ack", irq, 0);
                bus_wr(LOCK, 16'h0);
            end
        end
        sum = 0;
        for (int m = 1; m <= 6; m++) begin
            read_tally(m, v);
            chk($sformatf("R9 tally board %0d", m), v, 16'(exp_cnt[m]));
            sum += int'(v);
        end
        chk("R6 tally sum equals acquisitions", sum - 1, acquired);
    endtask

    task automatic t_saturate;
        logic [15:0] v;
        bus_wr(OWNER, 16'd9);
        @(negedge clk);
        loc_req = 1; loc_we = 1; loc_addr = INC;
        repeat (65540) @(posedge clk);
        @(negedge clk);
        loc_req = 0; loc_we = 0;
        read_tally(9, v);
        chk("R7 tally saturates", v, 16'hFFFF);
        loc_wr(INC, 0);
        read_tally(9, v);
        chk("R7 tally holds at max", v, 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        t_reset;
        t_plain;
        t_owner_err;
        t_rmw;
        t_mailbox;
        t_stall;
        t_compete;
        t_saturate;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule